// File: doc/BRIEF.md
# Vector-Scalar Row Product Engine

This block produces one segment of a row of the matrix product C = A x B. It holds up to 32 column positions of that row, and each position has its own running sum. On each step, one signed element of the current row of A is sent to every lane at once. The block multiplies it by the element of a row of B held in that lane, and each lane adds the product into its own accumulator. Partial sums never move between lanes, so the block has no reduction tree. Each lane's dot product stays independent until the end.

A controller starts the engine with a step count k and an active vector length. For every step it supplies one scalar and one vector, each with its own valid/ready pair. After k steps the engine presents all lane sums together on the result port, lane 0 in the lowest bits. The result waits there until the consumer accepts it. Fetching operands, stepping through rows and column groups, and floating point all stay outside the block.

Top module: `vsmm_engine`

## Requirements
- R1: After reset, res_valid, sc_ready and vec_ready are all 0, and every accumulator and lane-valid bit is 0.
- R2: An accepted start clears every lane accumulator to zero. A result never contains terms from an earlier run.
- R3: Each accepted step adds the signed product sc_data x vec_data[l] into accumulator l of every active lane l. The product and the sum are kept at full precision in a 40-bit two's complement accumulator.
- R4: A step is taken only in a cycle where sc_valid and vec_valid are both 1 while the engine is running. sc_ready is 1 only while running with vec_valid high, and vec_ready is 1 only while running with sc_valid high. A scalar or a vector offered alone is not consumed.
- R5: res_valid is 0 while steps remain. It is 1 in the cycle after the k-th step is accepted. Lane l's sum is in res_data[40*l+39 : 40*l].
- R6: While res_valid is 1 and res_ready is 0, res_valid stays 1 and res_data does not change. After a cycle with res_valid and res_ready both 1, res_valid is 0 and the engine is idle.
- R7: Lane l is active when l < cfg_vl, so a value of 32 or more enables every lane and 0 enables none. res_lane_valid[l] is 1 exactly for the active lanes. An inactive lane reports a sum of 0 whatever vector data it received.
- R8: With cfg_k = 0, res_valid is 1 in the cycle after start. The active lanes report zero sums and no operand is accepted.
- R9: A start pulse while a run or a result is pending is ignored, and so are cfg_k and cfg_vl outside the start cycle.
- R10: With cfg_k up to 511, no sum overflows. For example, 256 steps of (-32768) x (-32768) give exactly 2^38 in every active lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only while idle |
| cfg_k | input | 9 | Number of steps for the run |
| cfg_vl | input | 6 | Active vector length (lanes below it are active) |
| sc_valid | input | 1 | Scalar operand offered |
| sc_data | input | 16 | Signed scalar element of A |
| sc_ready | output | 1 | Scalar accepted this cycle when sc_valid is 1 |
| vec_valid | input | 1 | Vector operand offered |
| vec_data | input | 512 | 32 signed 16-bit elements of B, lane 0 lowest |
| vec_ready | output | 1 | Vector accepted this cycle when vec_valid is 1 |
| res_valid | output | 1 | Result group present |
| res_ready | input | 1 | Consumer takes the result group |
| res_data | output | 1280 | 32 signed 40-bit sums, lane 0 lowest |
| res_lane_valid | output | 32 | Per-lane active flag for the result group |

## Verification
The bench sweeps every vector length from 0 to 33 against known sums. An engine that decodes the active-lane mask off by one leaks sums into a lane that should stay silent, or loses the top active lane. Between steps the bench offers scalars and vectors on their own with junk data. An engine that takes either handshake alone then folds junk into the sums or drifts out of step with the operand stream. Runs follow one another with no reset, which catches an accumulator that is never cleared. Further cases cover the k = 0 path, a start pulse in the middle of a run, and long result backpressure. A 256-step run of the most negative operands exposes any truncation or sign-extension slip in the 40-bit sums.

// File: rtl/vsmm_pkg.sv
package vsmm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_OUT  = 2'd2
   } vsmm_state_e;
endpackage

// File: rtl/vsmm_ctrl.sv
module vsmm_ctrl
   import vsmm_pkg::*;
#(
   parameter int KW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [KW-1:0] cfg_k,
   input  logic          sc_valid,
   input  logic          vec_valid,
   input  logic          res_ready,
   output logic          sc_ready,
   output logic          vec_ready,
   output logic          res_valid,
   output logic          clear,
   output logic          step,
   output vsmm_state_e   state
);
   logic [KW-1:0] remain_q;
   logic          running;

   assign running   = (state == ST_RUN);
   assign sc_ready  = running && vec_valid;
   assign vec_ready = running && sc_valid;
   assign step      = running && sc_valid && vec_valid;
   assign clear     = (state == ST_IDLE) && start;
   assign res_valid = (state == ST_OUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         remain_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               remain_q <= cfg_k;
               state    <= (cfg_k == '0) ? ST_OUT : ST_RUN;
            end
            ST_RUN: if (step) begin
               remain_q <= remain_q - 1'b1;
               if (remain_q == KW'(1)) state <= ST_OUT;
            end
            ST_OUT: if (res_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vsmm_mask.sv
module vsmm_mask #(
   parameter int LANES = 32,
   parameter int VLW   = 6
) (
   input  logic [VLW-1:0]   vl,
   output logic [LANES-1:0] mask
);
   for (genvar l = 0; l < LANES; l++) begin : g_bit
      assign mask[l] = (vl > VLW'(l));
   end
endmodule

// File: rtl/vsmm_lane.sv
module vsmm_lane #(
   parameter int DW = 16,
   parameter int AW = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 step,
   input  logic                 active,
   input  logic signed [DW-1:0] scal,
   input  logic signed [DW-1:0] elem,
   output logic signed [AW-1:0] acc
);
   localparam int PW = 2 * DW;
   logic signed [PW-1:0] prod;
   logic signed [AW-1:0] prod_ext;

   assign prod     = scal * elem;
   assign prod_ext = {{(AW - PW){prod[PW-1]}}, prod};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              acc <= '0;
      else if (clear)          acc <= '0;
      else if (step && active) acc <= acc + prod_ext;
   end
endmodule

// File: rtl/vsmm_engine.sv
module vsmm_engine
   import vsmm_pkg::*;
#(
   parameter int LANES = 32,
   parameter int DW    = 16,
   parameter int AW    = 40,
   parameter int KW    = 9,
   parameter int VLW   = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [KW-1:0]       cfg_k,
   input  logic [VLW-1:0]      cfg_vl,
   input  logic                sc_valid,
   input  logic [DW-1:0]       sc_data,
   output logic                sc_ready,
   input  logic                vec_valid,
   input  logic [LANES*DW-1:0] vec_data,
   output logic                vec_ready,
   output logic                res_valid,
   input  logic                res_ready,
   output logic [LANES*AW-1:0] res_data,
   output logic [LANES-1:0]    res_lane_valid
);
   localparam int MIN_AW = 2 * DW - 1 + KW;

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("vsmm_engine: LANES must lie in 1..64");
   end
   if (AW < MIN_AW) begin : g_bad_aw
      $error("vsmm_engine: AW too narrow for DW and KW");
   end
   if (VLW < $clog2(LANES + 1)) begin : g_bad_vlw
      $error("vsmm_engine: VLW cannot express LANES");
   end

   vsmm_state_e      state;
   logic             clear;
   logic             step;
   logic [LANES-1:0] mask_next;
   logic [LANES-1:0] mask_q;

   vsmm_ctrl #(.KW(KW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_k     (cfg_k),
      .sc_valid  (sc_valid),
      .vec_valid (vec_valid),
      .res_ready (res_ready),
      .sc_ready  (sc_ready),
      .vec_ready (vec_ready),
      .res_valid (res_valid),
      .clear     (clear),
      .step      (step),
      .state     (state)
   );

   vsmm_mask #(.LANES(LANES), .VLW(VLW)) u_mask (
      .vl   (cfg_vl),
      .mask (mask_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '0;
      else if (clear) mask_q <= mask_next;
   end

   assign res_lane_valid = mask_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [AW-1:0] acc;
      vsmm_lane #(.DW(DW), .AW(AW)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear  (clear),
         .step   (step),
         .active (mask_q[l]),
         .scal   (sc_data),
         .elem   (vec_data[l*DW +: DW]),
         .acc    (acc)
      );
      assign res_data[l*AW +: AW] = acc;
   end
endmodule

// File: rtl/vsmm_chk.sv
module vsmm_chk #(
   parameter int LANES = 32,
   parameter int AW    = 40
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sc_valid,
   input logic                sc_ready,
   input logic                vec_valid,
   input logic                vec_ready,
   input logic                res_valid,
   input logic                res_ready,
   input logic [LANES*AW-1:0] res_data,
   input logic [LANES-1:0]    res_lane_valid
);
   // R4
   pair_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && sc_ready) |-> (vec_valid && vec_ready));

   // R4
   pair_fire_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_ready) |-> (sc_valid && sc_ready));

   // R5
   no_intake_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (!sc_ready && !vec_ready));

   // R6
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_lane_valid)));

   // R6
   res_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ready) |=> !res_valid);

   // R7
   mask_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $onehot0(res_lane_valid + 1'b1));

   for (genvar l = 0; l < LANES; l++) begin : g_idle_lane
      // R7
      idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && !res_lane_valid[l]) |-> (res_data[l*AW +: AW] == '0));
   end
endmodule

bind vsmm_engine vsmm_chk #(.LANES(LANES), .AW(AW)) u_vsmm_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sc_valid       (sc_valid),
   .sc_ready       (sc_ready),
   .vec_valid      (vec_valid),
   .vec_ready      (vec_ready),
   .res_valid      (res_valid),
   .res_ready      (res_ready),
   .res_data       (res_data),
   .res_lane_valid (res_lane_valid)
);

// File: tb/vsmm_engine_test.sv
module vsmm_engine_test;
   localparam int L  = 32;
   localparam int DW = 16;
   localparam int AW = 40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [8:0]      cfg_k = '0;
   logic [5:0]      cfg_vl = '0;
   logic            sc_valid = 1'b0;
   logic [DW-1:0]   sc_data = '0;
   logic            sc_ready;
   logic            vec_valid = 1'b0;
   logic [L*DW-1:0] vec_data = '0;
   logic            vec_ready;
   logic            res_valid;
   logic            res_ready = 1'b0;
   logic [L*AW-1:0] res_data;
   logic [L-1:0]    res_lane_valid;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;

   int     a_v [256];
   int     b_v [256][L];
   longint expv [L];

   always #5 clk = ~clk;

   vsmm_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_k(cfg_k), .cfg_vl(cfg_vl),
      .sc_valid(sc_valid), .sc_data(sc_data), .sc_ready(sc_ready),
      .vec_valid(vec_valid), .vec_data(vec_data), .vec_ready(vec_ready),
      .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
      .res_lane_valid(res_lane_valid)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp, input string what);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int gen(input int seed, input int t, input int l);
      int v;
      v = (seed * 7919 + t * 131 + l * 977 + t * l * 31 + seed * l * 13) % 65536;
      return v - 32768;
   endfunction

   task automatic run_case(input int k, input int vl, input int seed, input bit extreme,
                           input bit stall, input int bp, input bit midstart, input string req);
      for (int t = 0; t < k; t++) begin
         a_v[t] = extreme ? -32768 : gen(seed, t, 99);
         for (int l = 0; l < L; l++) b_v[t][l] = extreme ? -32768 : gen(seed + 1, t, l);
      end
      for (int l = 0; l < L; l++) begin
         expv[l] = 0;
         if (l < vl)
            for (int t = 0; t < k; t++) expv[l] += longint'(a_v[t]) * longint'(b_v[t][l]);
      end
      @(negedge clk);
      start = 1'b1; cfg_k = 9'(k); cfg_vl = 6'(vl);
      @(negedge clk);
      start = 1'b0; cfg_k = 9'd3; cfg_vl = 6'd1;
      if (k == 0) begin
         chk(res_valid == 1'b1, "R8", longint'(res_valid), 1, "res_valid one cycle after start with k=0");
      end else begin
         #1;
         chk(!sc_ready && !vec_ready, "R4", longint'({sc_ready, vec_ready}), 0, "ready with no operands offered");
      end
      for (int t = 0; t < k; t++) begin
         chk(res_valid == 1'b0, "R5", longint'(res_valid), 0, "res_valid before last step");
         if (stall) begin
            sc_valid = 1'b1; sc_data = 16'h7777; vec_valid = 1'b0;
            if (midstart && t == 1) begin
               start = 1'b1; cfg_k = 9'd1; cfg_vl = 6'd2;
            end
            #1;
            chk(sc_ready == 1'b0, "R4", longint'(sc_ready), 0, "sc_ready with scalar alone");
            @(negedge clk);
            start = 1'b0;
            sc_valid = 1'b0; vec_valid = 1'b1;
            for (int l = 0; l < L; l++) vec_data[l*DW +: DW] = 16'h1234 + 16'(l);
            #1;
            chk(vec_ready == 1'b0, "R4", longint'(vec_ready), 0, "vec_ready with vector alone");
            @(negedge clk);
         end
         sc_valid = 1'b1; vec_valid = 1'b1; sc_data = 16'(a_v[t]);
         for (int l = 0; l < L; l++) vec_data[l*DW +: DW] = 16'(b_v[t][l]);
         #1;
         chk(sc_ready && vec_ready, "R4", longint'({sc_ready, vec_ready}), 3, "both ready when both offered");
         @(negedge clk);
      end
      sc_valid = 1'b0; vec_valid = 1'b0;
      chk(res_valid == 1'b1, "R5", longint'(res_valid), 1, "res_valid after last step");
      for (int c = 0; c < bp; c++) begin
         @(negedge clk);
         chk(res_valid == 1'b1, "R6", longint'(res_valid), 1, "res_valid held under backpressure");
      end
      for (int l = 0; l < L; l++) begin
         longint act;
         act = longint'($signed(res_data[l*AW +: AW]));
         chk(act == expv[l], (l < vl) ? req : "R7", act, expv[l], $sformatf("lane %0d sum", l));
         chk(res_lane_valid[l] == (l < vl), "R7", longint'(res_lane_valid[l]), longint'(l < vl),
             $sformatf("lane %0d valid flag", l));
      end
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      chk(res_valid == 1'b0, "R6", longint'(res_valid), 0, "res_valid after accept");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!res_valid && !sc_ready && !vec_ready, "R1", longint'({res_valid, sc_ready, vec_ready}), 0, "outputs in reset");
      chk(res_lane_valid == '0, "R1", longint'(res_lane_valid), 0, "lane flags in reset");
      chk(res_data == '0, "R1", longint'(res_data[63:0]), 0, "sums in reset");
      rst_n = 1'b1;
      @(negedge clk);
      // R3 and R7 across all vector lengths; back-to-back runs exercise R2
      for (int vl = 0; vl <= 33; vl++)
         run_case(vl % 5 + 1, vl, vl * 3 + 1, 1'b0, vl % 2 == 1, vl % 3, 1'b0, "R2");
      // R8 zero-length runs
      run_case(0, 32, 5, 1'b0, 1'b0, 1, 1'b0, "R8");
      run_case(0, 5, 6, 1'b0, 1'b0, 0, 1'b0, "R8");
      // R9 start pulse during a run, with stalls (R4)
      run_case(7, 32, 11, 1'b0, 1'b1, 2, 1'b1, "R9");
      // R3 long mixed run
      run_case(40, 17, 21, 1'b0, 1'b1, 4, 1'b0, "R3");
      // R10 extreme operands, 256 steps
      run_case(256, 32, 0, 1'b1, 1'b0, 1, 1'b0, "R10");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule